// File: doc/BRIEF.md
# Interval Countdown Alarm

This block is a relative alarm timer. Software writes a time interval, given as days, hours, minutes and seconds, into a single register. Each pulse of a one-hertz tick then counts the interval down by one second. The fields borrow from each other the way a clock does. When the interval runs out, a sticky pending bit is set. An interrupt line goes high when the pending bit is set and the interrupt is enabled.

Four word-wide registers sit on a simple memory-mapped bus:

- the interval,
- a count enable,
- an interrupt enable,
- the pending status.

A read of the interval returns the live remaining count. The pending bit is cleared by writing a one to it. The expected software sequence is: disable counting, clear the pending bit, load the interval, then enable.

Top module: `alarm_cntdn_top`

## Requirements
- R1: After reset, every register reads zero and irq_o is low.
- R2: The interval register is at address 0x0C, with seconds in [5:0], minutes in [13:8], hours in [20:16] and days in [28:21]. A write loads those fields, and the other bits are dropped. A read returns the live remaining count in the same layout.
- R3: Writing zero to the interval register clears the count to zero.
- R4: The count enable is bit 8 at address 0x14, and no other bit of that register is stored. While the enable is clear, tick pulses leave the count unchanged.
- R5: While the count is enabled and non-zero, each tick pulse takes one second off the count:
  - zero seconds reload as 59 and borrow a minute;
  - zero minutes reload as 59 and borrow an hour;
  - zero hours reload as 23 and borrow a day.
- R6: The tick that takes the count from one second to zero sets the pending bit (bit 0 at address 0x1C). The count then stays at zero, and later ticks do not set the pending bit again. Enabling a count that is already zero never sets the pending bit.
- R7: Writing 1 to pending bit 0 clears it. Writing 0 to it has no effect.
- R8: irq_o is high exactly when the pending bit and the interrupt enable (bit 0 at address 0x18) are both set.
- R9: When the expiry and a write-one-to-clear of the pending bit fall in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse each second |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Some rules are checked by assertions on every cycle:

- a zero count holds;
- the count is stable when no step and no load is applied;
- a zero-seconds step reloads 59;
- an expiry sets the pending bit;
- a one-write without a coincident expiry clears the pending bit.

Other behaviour only the bench scenarios can show:

- a borrow that ripples across all four fields;
- the pending bit setting only once over a run of extra ticks;
- which bits of each control register are stored;
- the interrupt being masked by its enable;
- the same-cycle race between expiry and clear.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DAY_W = 8;
  localparam int HR_W  = 5;
  localparam int MS_W  = 6;

  localparam logic [7:0] ADDR_IVL  = 8'h0C;
  localparam logic [7:0] ADDR_CEN  = 8'h14;
  localparam logic [7:0] ADDR_IEN  = 8'h18;
  localparam logic [7:0] ADDR_PEND = 8'h1C;

  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = 8;
  localparam int HR_LSB  = 16;
  localparam int DAY_LSB = 21;
  localparam int CEN_BIT = 8;

  localparam logic [MS_W-1:0] MS_MAX = MS_W'(59);
  localparam logic [HR_W-1:0] HR_MAX = HR_W'(23);

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MS_W-1:0]  min;
    logic [MS_W-1:0]  sec;
  } ivl_t;
endpackage

// File: rtl/alarm_counter.sv
module alarm_counter
  import alarm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  ivl_t load_val_i,
  input  logic step_i,
  output ivl_t cnt_o,
  output logic expire_o
);
  ivl_t cnt_q, cnt_d;
  logic is_zero, is_last;

  assign is_zero = (cnt_q == '0);
  assign is_last = (cnt_q.day == '0) && (cnt_q.hr == '0) &&
                   (cnt_q.min == '0) && (cnt_q.sec == MS_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (step_i && !is_zero) begin
      if (cnt_q.sec != '0) begin
        cnt_d.sec = cnt_q.sec - MS_W'(1);
      end else begin
        cnt_d.sec = MS_MAX;
        if (cnt_q.min != '0) begin
          cnt_d.min = cnt_q.min - MS_W'(1);
        end else begin
          cnt_d.min = MS_MAX;
          if (cnt_q.hr != '0) begin
            cnt_d.hr = cnt_q.hr - HR_W'(1);
          end else begin
            cnt_d.hr  = HR_MAX;
            cnt_d.day = cnt_q.day - DAY_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // load takes priority over a tick in the same cycle
  assign expire_o = step_i && !load_i && is_last;
  assign cnt_o    = cnt_q;

  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_zero && !load_i) |=> (cnt_q == '0));  // R6
  AST_STALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(cnt_q));  // R4
  AST_SEC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !is_zero && cnt_q.sec == '0) |=> (cnt_q.sec == MS_MAX));  // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == '0) |=> is_zero);  // R3
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  ivl_t              cnt_i,
  input  logic              expire_i,
  output logic              load_o,
  output ivl_t              load_val_o,
  output logic              cen_o,
  output logic              irq_o
);
  logic wr, wr_cen, wr_ien, w1c;
  logic cen_q, ien_q, pend_q;
  logic unused_wbits;

  assign wr     = req_i && we_i;
  assign load_o = wr && (addr_i == ADDR_W'(ADDR_IVL));
  assign wr_cen = wr && (addr_i == ADDR_W'(ADDR_CEN));
  assign wr_ien = wr && (addr_i == ADDR_W'(ADDR_IEN));
  assign w1c    = wr && (addr_i == ADDR_W'(ADDR_PEND)) && wdata_i[0];

  assign load_val_o.sec = wdata_i[SEC_LSB +: MS_W];
  assign load_val_o.min = wdata_i[MIN_LSB +: MS_W];
  assign load_val_o.hr  = wdata_i[HR_LSB  +: HR_W];
  assign load_val_o.day = wdata_i[DAY_LSB +: DAY_W];

  assign unused_wbits = ^{wdata_i[DATA_W-1:DAY_LSB+DAY_W], wdata_i[15:14], wdata_i[7:6]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q  <= 1'b0;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_cen) cen_q <= wdata_i[CEN_BIT];
      if (wr_ien) ien_q <= wdata_i[0];
      // set beats clear
      if (expire_i)  pend_q <= 1'b1;
      else if (w1c)  pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(ADDR_IVL): begin
        rdata_o[SEC_LSB +: MS_W]  = cnt_i.sec;
        rdata_o[MIN_LSB +: MS_W]  = cnt_i.min;
        rdata_o[HR_LSB  +: HR_W]  = cnt_i.hr;
        rdata_o[DAY_LSB +: DAY_W] = cnt_i.day;
      end
      ADDR_W'(ADDR_CEN):  rdata_o[CEN_BIT] = cen_q;
      ADDR_W'(ADDR_IEN):  rdata_o[0] = ien_q;
      ADDR_W'(ADDR_PEND): rdata_o[0] = pend_q;
      default: rdata_o = '0;
    endcase
  end

  assign cen_o = cen_q;
  assign irq_o = pend_q && ien_q;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> pend_q);  // R9
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c && !expire_i) |=> !pend_q);  // R7
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !w1c) |=> pend_q);  // R6
endmodule

// File: rtl/alarm_cntdn_top.sv
module alarm_cntdn_top
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ivl_t cnt, load_val;
  logic load, cen, expire, step;

  assign step = cen && tick_i;

  alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cnt_i      (cnt),
    .expire_i   (expire),
    .load_o     (load),
    .load_val_o (load_val),
    .cen_o      (cen),
    .irq_o      (irq_o)
  );

  alarm_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .step_i     (step),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  AST_NO_TICK_NO_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> (tick_i && cen));  // R4
endmodule

// File: tb/alarm_cntdn_top_tb_top.sv
`timescale 1ns/1ps
module alarm_cntdn_top_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alarm_cntdn_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] d; logic [4:0] h; logic [5:0] m; logic [5:0] s;
    logic [7:0] n;
    logic [7:0] ed; logic [4:0] eh; logic [5:0] em; logic [5:0] es;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd0,   5'd0,  6'd0,  6'd10, 8'd3, 8'd0,   5'd0,  6'd0,  6'd7},
    '{8'd0,   5'd0,  6'd1,  6'd0,  8'd1, 8'd0,   5'd0,  6'd0,  6'd59},
    '{8'd0,   5'd1,  6'd0,  6'd0,  8'd1, 8'd0,   5'd0,  6'd59, 6'd59},
    '{8'd1,   5'd0,  6'd0,  6'd0,  8'd1, 8'd0,   5'd23, 6'd59, 6'd59},
    '{8'd2,   5'd0,  6'd0,  6'd1,  8'd2, 8'd1,   5'd23, 6'd59, 6'd59},
    '{8'd255, 5'd23, 6'd59, 6'd59, 8'd5, 8'd255, 5'd23, 6'd59, 6'd54}
  };

  function automatic logic [31:0] pk(int d, int h, int m, int s);
    return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a; #1; d = rdata; req = 0;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h0C, v); chk("R1 ivl", v, 0);
    rd(8'h14, v); chk("R1 cen", v, 0);
    rd(8'h18, v); chk("R1 ien", v, 0);
    rd(8'h1C, v); chk("R1 pend", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2/R5 vector walk
    foreach (VECS[i]) begin
      wr(8'h14, 0);
      wr(8'h0C, pk(VECS[i].d, VECS[i].h, VECS[i].m, VECS[i].s) | 32'hE000_C0C0);
      rd(8'h0C, v); chk("R2 load", v, pk(VECS[i].d, VECS[i].h, VECS[i].m, VECS[i].s));
      wr(8'h14, 32'h100);
      tk(VECS[i].n);
      rd(8'h0C, v); chk("R5 borrow", v, pk(VECS[i].ed, VECS[i].eh, VECS[i].em, VECS[i].es));
    end
    rd(8'h1C, v); chk("R6 no early pend", v, 0);

    // R4 disabled and stray bits
    wr(8'h14, 32'hFFFF_FEFF);
    rd(8'h14, v); chk("R4 only bit8", v, 0);
    wr(8'h0C, pk(0, 0, 5, 0));
    tk(3);
    rd(8'h0C, v); chk("R4 hold", v, pk(0, 0, 5, 0));
    // R3
    wr(8'h0C, 0);
    rd(8'h0C, v); chk("R3 clear", v, 0);
    // R6 zero count never fires
    wr(8'h14, 32'h100);
    tk(2);
    rd(8'h1C, v); chk("R6 zero no pend", v, 0);

    // R6/R8 expiry
    wr(8'h14, 0);
    wr(8'h0C, 2);
    wr(8'h18, 1);
    wr(8'h14, 32'h100);
    tk(1);
    rd(8'h1C, v); chk("R6 not yet", v, 0);
    tk(1);
    rd(8'h1C, v); chk("R6 pend", v, 1);
    chk("R8 irq on", 32'(irq), 1);
    tk(3);
    rd(8'h0C, v); chk("R6 hold zero", v, 0);
    // R7
    wr(8'h1C, 0);
    rd(8'h1C, v); chk("R7 write0", v, 1);
    // R8 mask
    wr(8'h18, 0);
    chk("R8 masked", 32'(irq), 0);
    wr(8'h18, 1);
    chk("R8 unmasked", 32'(irq), 1);
    wr(8'h1C, 1);
    rd(8'h1C, v); chk("R7 w1c", v, 0);
    chk("R8 irq off", 32'(irq), 0);
    tk(3);
    rd(8'h1C, v); chk("R6 once", v, 0);

    // R9 set beats clear
    wr(8'h0C, 1);
    @(negedge clk); tick = 1; req = 1; we = 1; addr = 8'h1C; wdata = 1;
    @(negedge clk); tick = 0; req = 0; we = 0; wdata = 0;
    rd(8'h1C, v); chk("R9 set wins", v, 1);
    rd(8'h0C, v); chk("R9 count zero", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule